// File: doc/BRIEF.md
# Stream Routing Instruction Allocator

This block sits at the entry of a ring node that steers pixel streams. Each stream that arrives, whether from one of four ring channels, the external input or the frame-memory input, brings a routing instruction. The allocator queues these requests and looks up the fixed resource cost of each instruction. It grants a request only when every unit that the request needs is free. On a grant it reserves those units and reports which buffer and ring-output index the datapath must select for the rest of the stream. After a fixed adaptation delay it raises a per-source flow enable.

Six kinds of unit are tracked: upper and lower channel buffers (four of each), ring outputs (four), and one each of external output, frame-memory read port and frame-memory write port. A stream holds its units until its end-of-frame marker is reported. A stream with no instruction takes the bypass path, which uses no buffer. A refused request stays at the head of a small in-order queue and is tried again every cycle. A request whose source index is beyond the last source is discarded.

Top module: `stream_route_alloc`

## Requirements
- R1: After reset no grant is reported, every flow and bypass enable is low, and the request queue is ready.
- R2: Instruction codes are 1 direct forward, 2 forward via another channel, 3 frame-memory read, 4 frame-memory store and 5 external output. The grant's 6-bit usage mask has bit 0 upper buffer, bit 1 lower buffer, bit 2 ring output, bit 3 external output, bit 4 frame-memory read port and bit 5 frame-memory write port. Code 1 uses a ring output, plus an upper buffer when the parallel mode input is high. Code 2 uses an upper buffer and a ring output. Code 3 uses an upper buffer and the read port. Code 4 uses a lower buffer and the write port. Code 5 uses a lower buffer and the external output.
- R3: A request is granted only when every unit its mask needs has a free instance. Buffer and ring-output instances are handed out lowest free index first and reported as indices with the grant.
- R4: A source's flow enable rises a fixed number of cycles after the cycle its grant is reported: 2 for direct forward, 6 for codes 2 and 5 and for direct forward in parallel mode, 8 for codes 3 and 4.
- R5: Codes 0, 6 and 7 select bypass. The grant carries an all-zero mask, and the source's bypass and flow enables are high in the same cycle as its grant.
- R6: An end-of-frame for an active source frees its units and drops its flow and bypass enables at the next edge, and a waiting request can use those units from the following cycle. An end-of-frame for an idle source changes nothing.
- R7: A request is refused while its source already holds a stream or while any needed unit is taken. A refused request stays at the queue head and is retried each cycle, and requests behind it are granted strictly in arrival order.
- R8: The queue holds four requests, and the ready output is low while four are waiting.
- R9: A request accepted at a clock edge, with its source idle and its units free, is reported as granted one cycle after it is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| par_mode | input | 1 | Parallel execution mode; direct forward then needs an upper buffer |
| req_valid | input | 1 | Routing request present |
| req_src | input | 3 | Source index of the request (0..5) |
| req_code | input | 3 | Routing instruction code |
| req_ready | output | 1 | Queue can accept a request |
| eof_valid | input | 1 | End-of-frame marker passed for a source |
| eof_src | input | 3 | Source whose frame ended |
| gnt_valid | output | 1 | One-cycle grant report |
| gnt_src | output | 3 | Granted source |
| gnt_code | output | 3 | Granted instruction code |
| gnt_uses | output | 6 | Usage mask of the grant |
| gnt_up_idx | output | 2 | Upper buffer chosen |
| gnt_dn_idx | output | 2 | Lower buffer chosen |
| gnt_ring_idx | output | 2 | Ring output chosen |
| flow_en | output | 6 | Per-source enable to let pixels flow |
| bypass_en | output | 6 | Per-source select of the buffer-free path |

## Verification
The release of one stream and the grant of a waiting request can fall in the same cycle. The bench provokes this by leaving a request blocked at the queue head, on a busy source, an exhausted ring-output pool or a taken frame-memory port. It then reports end-of-frame for the stream holding the unit. The scoreboard expects the waiting grant exactly two cycles after the end-of-frame is driven, with the freed instance as the lowest-index choice, and expects the requests queued behind it to follow in order.

// File: rtl/sra_pkg.sv
package sra_pkg;

    localparam int LAT_W  = 4;
    localparam int KINDS  = 6;

    typedef enum logic [2:0] {
        OP_PASS   = 3'd0,
        OP_DIRECT = 3'd1,
        OP_XCHG   = 3'd2,
        OP_FMRD   = 3'd3,
        OP_FMWR   = 3'd4,
        OP_EXT    = 3'd5
    } route_op_e;

    // bit 0 upper .. bit 5 frame-memory write
    typedef struct packed {
        logic fm_wr;
        logic fm_rd;
        logic ext;
        logic ring;
        logic dn;
        logic up;
    } res_t;

    function automatic logic is_pass(input logic [2:0] code);
        return (code == OP_PASS) || (code > OP_EXT);
    endfunction

    function automatic res_t route_cost(input logic [2:0] code, input logic par);
        res_t c;
        c = '0;
        case (code)
            OP_DIRECT: begin c.ring = 1'b1; c.up = par; end
            OP_XCHG:   begin c.up = 1'b1; c.ring = 1'b1; end
            OP_FMRD:   begin c.up = 1'b1; c.fm_rd = 1'b1; end
            OP_FMWR:   begin c.dn = 1'b1; c.fm_wr = 1'b1; end
            OP_EXT:    begin c.dn = 1'b1; c.ext = 1'b1; end
            default:   c = '0;
        endcase
        return c;
    endfunction

    // base routing 2, buffer handshake +4, frame memory setup +2
    function automatic logic [LAT_W-1:0] route_latency(input res_t c, input logic pass);
        logic [LAT_W-1:0] l;
        if (pass) begin
            l = '0;
        end else begin
            l = LAT_W'(2);
            if (c.up || c.dn)       l = l + LAT_W'(4);
            if (c.fm_rd || c.fm_wr) l = l + LAT_W'(2);
        end
        return l;
    endfunction

endpackage

// File: rtl/sra_req_fifo.sv
module sra_req_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 6
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         nonempty,
    output logic         full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem_q [DEPTH];
    logic [PW-1:0] rd_q, wr_q;
    logic [CW-1:0] cnt_q;

    function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    assign dout     = mem_q[rd_q];
    assign nonempty = (cnt_q != '0);
    assign full     = (cnt_q == CW'(DEPTH));

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q  <= '0;
            wr_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (push) begin
                mem_q[wr_q] <= din;
                wr_q        <= nxt(wr_q);
            end
            if (pop) rd_q <= nxt(rd_q);
            case ({push, pop})
                2'b10:   cnt_q <= cnt_q + CW'(1);
                2'b01:   cnt_q <= cnt_q - CW'(1);
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    p_no_overflow_r8: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CW'(DEPTH));
    p_pop_nonempty_r7: assert property (@(posedge clk) disable iff (rst)
        pop |-> nonempty);

endmodule

// File: rtl/sra_pool.sv
module sra_pool #(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          alloc,
    input  logic          rel,
    input  logic [IW-1:0] rel_idx,
    output logic          avail,
    output logic [IW-1:0] pick
);
    logic [N-1:0] busy_q;

    // lowest free instance wins
    always_comb begin
        pick  = '0;
        avail = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!busy_q[i]) begin
                pick  = IW'(i);
                avail = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= '0;
        end else begin
            for (int i = 0; i < N; i++) begin
                if (alloc && pick == IW'(i)) busy_q[i] <= 1'b1;
                if (rel && rel_idx == IW'(i)) busy_q[i] <= 1'b0;
            end
        end
    end

    p_alloc_needs_free_r3: assert property (@(posedge clk) disable iff (rst)
        alloc |-> avail);
    p_release_held_r6: assert property (@(posedge clk) disable iff (rst)
        rel |-> busy_q[rel_idx]);

endmodule

// File: rtl/sra_flow_timer.sv
module sra_flow_timer #(
    parameter int LW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [LW-1:0] lat,
    input  logic          clear,
    output logic          flow
);
    logic          act_q;
    logic [LW-1:0] cnt_q;

    assign flow = act_q && (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q <= 1'b0;
            cnt_q <= '0;
        end else if (clear) begin
            act_q <= 1'b0;
            cnt_q <= '0;
        end else if (load) begin
            act_q <= 1'b1;
            cnt_q <= lat;
        end else if (act_q && cnt_q != '0) begin
            cnt_q <= cnt_q - LW'(1);
        end
    end

    p_wait_after_load_r4: assert property (@(posedge clk) disable iff (rst)
        (load && !clear && lat != '0) |=> !flow);
    p_flow_holds_r4: assert property (@(posedge clk) disable iff (rst)
        (flow && !clear) |=> flow);

endmodule

// File: rtl/stream_route_alloc.sv
module stream_route_alloc
    import sra_pkg::*;
#(
    parameter int NUM_SRC    = 6,
    parameter int NUM_BUF    = 4,
    parameter int NUM_RING   = 4,
    parameter int FIFO_DEPTH = 4
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        par_mode,
    input  logic                        req_valid,
    input  logic [$clog2(NUM_SRC)-1:0]  req_src,
    input  logic [2:0]                  req_code,
    output logic                        req_ready,
    input  logic                        eof_valid,
    input  logic [$clog2(NUM_SRC)-1:0]  eof_src,
    output logic                        gnt_valid,
    output logic [$clog2(NUM_SRC)-1:0]  gnt_src,
    output logic [2:0]                  gnt_code,
    output logic [5:0]                  gnt_uses,
    output logic [$clog2(NUM_BUF)-1:0]  gnt_up_idx,
    output logic [$clog2(NUM_BUF)-1:0]  gnt_dn_idx,
    output logic [$clog2(NUM_RING)-1:0] gnt_ring_idx,
    output logic [NUM_SRC-1:0]          flow_en,
    output logic [NUM_SRC-1:0]          bypass_en
);
    localparam int SW  = $clog2(NUM_SRC);
    localparam int BW  = $clog2(NUM_BUF);
    localparam int RW  = $clog2(NUM_RING);
    localparam int IXW = (BW > RW) ? ((BW > 0) ? BW : 1) : ((RW > 0) ? RW : 1);

    typedef struct packed {
        logic [2:0]    code;
        logic [SW-1:0] src;
    } req_t;

    typedef struct packed {
        logic                      live;
        logic                      pass;
        logic [KINDS-1:0]          uses;
        logic [KINDS-1:0][IXW-1:0] idx;
    } hold_t;

    // ---------------- request queue ----------------
    req_t head;
    logic head_valid, q_full, q_pop, q_push;

    assign q_push    = req_valid && !q_full;
    assign req_ready = !q_full;

    sra_req_fifo #(.DEPTH(FIFO_DEPTH), .W($bits(req_t))) u_fifo (
        .clk      (clk),
        .rst      (rst),
        .push     (q_push),
        .din      ({req_code, req_src}),
        .pop      (q_pop),
        .dout     (head),
        .nonempty (head_valid),
        .full     (q_full)
    );

    // ---------------- admission ----------------
    hold_t              hold_q [NUM_SRC];
    hold_t              rel_rec;
    logic               head_live, src_ok, fits, do_grant, rel_hit, head_pass;
    res_t               need;
    logic [KINDS-1:0]   need_v, avail_v, alloc_v, rel_v;
    logic [KINDS-1:0][IXW-1:0] pick_v;

    assign need      = route_cost(head.code, par_mode);
    assign need_v    = need;
    assign head_pass = is_pass(head.code);
    assign src_ok    = 32'(head.src) < NUM_SRC;

    always_comb begin
        head_live = 1'b0;
        rel_rec   = '0;
        for (int s = 0; s < NUM_SRC; s++) begin
            if (head.src == SW'(s)) head_live = hold_q[s].live;
            if (eof_src == SW'(s))  rel_rec   = hold_q[s];
        end
    end

    assign fits     = ((need_v & ~avail_v) == '0);
    assign do_grant = head_valid && src_ok && !head_live && fits;
    assign q_pop    = head_valid && (do_grant || !src_ok);
    assign rel_hit  = eof_valid && rel_rec.live;
    assign alloc_v  = do_grant ? need_v : '0;
    assign rel_v    = rel_hit ? rel_rec.uses : '0;

    // ---------------- unit pools ----------------
    for (genvar k = 0; k < KINDS; k++) begin : g_pool
        localparam int UNITS = (k < 2) ? NUM_BUF : ((k == 2) ? NUM_RING : 1);
        sra_pool #(.N(UNITS), .IW(IXW)) u_pool (
            .clk     (clk),
            .rst     (rst),
            .alloc   (alloc_v[k]),
            .rel     (rel_v[k]),
            .rel_idx (rel_rec.idx[k]),
            .avail   (avail_v[k]),
            .pick    (pick_v[k])
        );
    end

    // ---------------- per-source records ----------------
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < NUM_SRC; s++) hold_q[s] <= '0;
        end else begin
            for (int s = 0; s < NUM_SRC; s++) begin
                if (rel_hit && eof_src == SW'(s)) hold_q[s].live <= 1'b0;
                if (do_grant && head.src == SW'(s)) begin
                    hold_q[s].live <= 1'b1;
                    hold_q[s].pass <= head_pass;
                    hold_q[s].uses <= need_v;
                    hold_q[s].idx  <= pick_v;
                end
            end
        end
    end

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_slot
        sra_flow_timer #(.LW(LAT_W)) u_timer (
            .clk   (clk),
            .rst   (rst),
            .load  (do_grant && head.src == SW'(s)),
            .lat   (route_latency(need, head_pass)),
            .clear (rel_hit && eof_src == SW'(s)),
            .flow  (flow_en[s])
        );
        assign bypass_en[s] = hold_q[s].live && hold_q[s].pass;
    end

    // ---------------- grant report ----------------
    logic [KINDS-1:0][IXW-1:0] gidx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            gnt_valid <= 1'b0;
            gnt_src   <= '0;
            gnt_code  <= '0;
            gnt_uses  <= '0;
            gidx_q    <= '0;
        end else begin
            gnt_valid <= do_grant;
            if (do_grant) begin
                gnt_src  <= head.src;
                gnt_code <= head.code;
                gnt_uses <= need_v;
                gidx_q   <= pick_v;
            end
        end
    end

    assign gnt_up_idx   = BW'(gidx_q[0]);
    assign gnt_dn_idx   = BW'(gidx_q[1]);
    assign gnt_ring_idx = RW'(gidx_q[2]);

    p_one_buffer_r2: assert property (@(posedge clk) disable iff (rst)
        gnt_valid |-> !(gnt_uses[0] && gnt_uses[1]));
    p_pass_free_r5: assert property (@(posedge clk) disable iff (rst)
        (gnt_valid && gnt_code == 3'd0) |-> (gnt_uses == 6'd0));
    p_release_stops_r6: assert property (@(posedge clk) disable iff (rst)
        rel_hit |=> !flow_en[$past(eof_src)] && !bypass_en[$past(eof_src)]);

endmodule

// File: tb/stream_route_alloc_bench.sv
`timescale 1ns/1ps
module stream_route_alloc_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       par_mode = 1'b0;
    logic       req_valid = 1'b0;
    logic [2:0] req_src = '0;
    logic [2:0] req_code = '0;
    logic       req_ready;
    logic       eof_valid = 1'b0;
    logic [2:0] eof_src = '0;
    logic       gnt_valid;
    logic [2:0] gnt_src, gnt_code;
    logic [5:0] gnt_uses;
    logic [1:0] gnt_up_idx, gnt_dn_idx, gnt_ring_idx;
    logic [5:0] flow_en, bypass_en;

    stream_route_alloc u_stream_route_alloc (
        .clk(clk), .rst(rst), .par_mode(par_mode),
        .req_valid(req_valid), .req_src(req_src), .req_code(req_code),
        .req_ready(req_ready), .eof_valid(eof_valid), .eof_src(eof_src),
        .gnt_valid(gnt_valid), .gnt_src(gnt_src), .gnt_code(gnt_code),
        .gnt_uses(gnt_uses), .gnt_up_idx(gnt_up_idx), .gnt_dn_idx(gnt_dn_idx),
        .gnt_ring_idx(gnt_ring_idx), .flow_en(flow_en), .bypass_en(bypass_en)
    );

    always #4 clk = ~clk;

    typedef struct {
        int src; int code; int uses; int up; int dn; int ring; int lat; int at;
    } exp_t;

    exp_t exp_q[$];
    exp_t em;
    int   checks = 0, errors = 0, cyc = 0, last_cyc = 0;
    int   gnt_cyc[6], exp_lat[6];
    bit   armed[6];
    logic [5:0] flow_prev = '0;
    bit   run = 1'b0, done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, expv);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send(input int s, input int code);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_src = 3'(s); req_code = 3'(code);
        last_cyc = cyc;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic eof(input int s);
        @(negedge clk);
        eof_valid = 1'b1; eof_src = 3'(s);
        last_cyc = cyc;
        @(negedge clk);
        eof_valid = 1'b0;
    endtask

    task automatic expect_g(input int s, input int code, input int uses, input int up,
                            input int dn, input int ring, input int lat, input int at);
        exp_t e;
        e.src = s; e.code = code; e.uses = uses; e.up = up; e.dn = dn;
        e.ring = ring; e.lat = lat; e.at = at;
        exp_q.push_back(e);
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (run && !rst) begin
            if (gnt_valid) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R7 unexpected grant src", int'(gnt_src), -1);
                end else begin
                    em = exp_q.pop_front();
                    chk(int'(gnt_src) == em.src, "R7 grant order src", int'(gnt_src), em.src);
                    chk(int'(gnt_code) == em.code, "R7 grant order code", int'(gnt_code), em.code);
                    chk(int'(gnt_uses) == em.uses, "R2 usage mask", int'(gnt_uses), em.uses);
                    if (em.uses[0]) chk(int'(gnt_up_idx) == em.up, "R3 upper index", int'(gnt_up_idx), em.up);
                    if (em.uses[1]) chk(int'(gnt_dn_idx) == em.dn, "R3 lower index", int'(gnt_dn_idx), em.dn);
                    if (em.uses[2]) chk(int'(gnt_ring_idx) == em.ring, "R3 ring index", int'(gnt_ring_idx), em.ring);
                    if (em.at >= 0) chk(cyc == em.at, "R9 R6 grant cycle", cyc, em.at);
                    if (em.uses == 0)
                        chk(bypass_en[em.src] == 1'b1, "R5 bypass with grant", int'(bypass_en[em.src]), 1);
                    gnt_cyc[em.src] = cyc;
                    exp_lat[em.src] = em.lat;
                    armed[em.src] = 1'b1;
                end
            end
            for (int s = 0; s < 6; s++) begin
                if (flow_en[s] && !flow_prev[s] && armed[s]) begin
                    chk(cyc - gnt_cyc[s] == exp_lat[s], "R4 flow delay", cyc - gnt_cyc[s], exp_lat[s]);
                    armed[s] = 1'b0;
                end
            end
            flow_prev = flow_en;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual 0 expected 1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst = 1'b0;
        run = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(gnt_valid == 1'b0, "R1 no grant", int'(gnt_valid), 0);
        chk(flow_en == 6'd0, "R1 flow low", int'(flow_en), 0);
        chk(bypass_en == 6'd0, "R1 bypass low", int'(bypass_en), 0);
        chk(req_ready == 1'b1, "R1 ready", int'(req_ready), 1);

        // each instruction on a free pool (R2 R3 R4 R9)
        send(0, 1); expect_g(0, 1, 4,  0, 0, 0, 2, last_cyc + 2);
        send(1, 2); expect_g(1, 2, 5,  0, 0, 1, 6, last_cyc + 2);
        send(2, 3); expect_g(2, 3, 17, 1, 0, 0, 8, last_cyc + 2);
        send(3, 4); expect_g(3, 4, 34, 0, 0, 0, 8, last_cyc + 2);
        send(4, 5); expect_g(4, 5, 10, 0, 1, 0, 6, last_cyc + 2);
        send(5, 1); expect_g(5, 1, 4,  0, 0, 2, 2, last_cyc + 2);
        idle(12);

        // R7 busy source refused, granted after its release (R6)
        send(0, 2);
        idle(6);
        chk(flow_en == 6'h3F, "R7 refused request leaves streams", int'(flow_en), 63);
        eof(0); expect_g(0, 2, 5, 2, 0, 0, 6, last_cyc + 2);
        idle(12);

        // R7 taken read port blocks head, later request waits in order
        eof(1);
        eof(4);
        send(1, 3);
        send(4, 5);
        idle(6);
        eof(2);
        expect_g(1, 3, 17, 0, 0, 0, 8, last_cyc + 2);
        expect_g(4, 5, 10, 0, 1, 0, 6, last_cyc + 3);
        idle(12);
        // R6 end-of-frame on an idle source
        eof(2);
        idle(3);
        chk(flow_en == 6'b111011, "R6 idle eof no effect", int'(flow_en), 59);

        // R8 queue fills behind a blocked head
        send(3, 4);
        send(2, 1);
        send(2, 1);
        send(2, 1);
        chk(req_ready == 1'b0, "R8 ready low when full", int'(req_ready), 0);
        idle(4);
        eof(3);
        expect_g(3, 4, 34, 0, 0, 0, 8, last_cyc + 2);
        expect_g(2, 1, 4, 0, 0, 1, 2, last_cyc + 3);
        idle(8);
        chk(req_ready == 1'b1, "R8 ready returns", int'(req_ready), 1);
        eof(2); expect_g(2, 1, 4, 0, 0, 1, 2, last_cyc + 2);
        idle(6);
        eof(2); expect_g(2, 1, 4, 0, 0, 1, 2, last_cyc + 2);
        idle(6);

        // release everything
        for (int s = 0; s < 6; s++) eof(s);
        idle(3);
        chk(flow_en == 6'd0, "R6 all released", int'(flow_en), 0);

        // R3 ring outputs exhausted, upper buffers exhausted
        send(0, 2); expect_g(0, 2, 5, 0, 0, 0, 6, last_cyc + 2);
        send(1, 2); expect_g(1, 2, 5, 1, 0, 1, 6, last_cyc + 2);
        send(2, 2); expect_g(2, 2, 5, 2, 0, 2, 6, last_cyc + 2);
        send(3, 2); expect_g(3, 2, 5, 3, 0, 3, 6, last_cyc + 2);
        send(4, 1);
        idle(5);
        eof(2); expect_g(4, 1, 4, 0, 0, 2, 2, last_cyc + 2);
        idle(3);
        send(5, 3); expect_g(5, 3, 17, 2, 0, 0, 8, last_cyc + 2);
        send(2, 2);
        idle(4);
        eof(5);
        idle(6);
        eof(0); expect_g(2, 2, 5, 0, 0, 0, 6, last_cyc + 2);
        idle(10);

        // parallel mode and bypass (R2 R4 R5)
        for (int s = 0; s < 6; s++) eof(s);
        idle(2);
        par_mode = 1'b1;
        send(0, 1); expect_g(0, 1, 5, 0, 0, 0, 6, last_cyc + 2);
        send(1, 0); expect_g(1, 0, 0, 0, 0, 0, 0, last_cyc + 2);
        send(2, 7); expect_g(2, 7, 0, 0, 0, 0, 0, last_cyc + 2);
        idle(8);
        chk(bypass_en == 6'b000110, "R5 bypass selects", int'(bypass_en), 6);
        chk(flow_en == 6'b000111, "R5 flow with bypass", int'(flow_en), 7);
        eof(1);
        chk(bypass_en == 6'b000100, "R5 R6 bypass dropped", int'(bypass_en), 4);
        par_mode = 1'b0;
        eof(0);
        eof(2);
        idle(4);
        chk(exp_q.size() == 0, "R7 all grants seen", exp_q.size(), 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule